// File: doc/BRIEF.md
# Serial Programming Command Receiver

This block is the target end of a three-wire in-system programming link. While the target's active-low reset pin is held low, an external host drives a serial clock and a data line into the block. The host sends instructions as fixed frames of four bytes. The block runs on a faster system clock and oversamples the serial clock. It shifts in each byte most significant bit first and keeps count of where each byte sits in the frame. It also drives reply bytes back on the return data line.

The block does not act on any instruction until the host has sent a valid unlock frame. The first byte of that frame is 0xAC and the second is 0x53. During the third byte of every frame, the block returns the byte it received second. This lets the host see whether the link is in step. Once the block is unlocked, each completed frame is passed to a memory execution unit as four bytes together with a one-cycle valid strobe. The block also gives an early strobe after the third byte. The execution unit uses it to return read data, which the block then shifts out as the fourth reply byte.

Top module: `isp_frontend`

## Requirements
- R1: After system reset, `miso` is 0, `linkEnabled` is 0, and `cmdValid`, `addrStrobe` and `cmdErase` are all low.
- R2: `mosi` is sampled on each rising `sck` edge, MSB first. The four bytes of a frame appear in receive order on `cmdOp`, `cmdAddrHi`, `cmdAddrLo` and `cmdData`.
- R3: `miso` changes only after a falling `sck` edge, or when the programming reset clears it. Each reply byte is shifted out MSB first. Its MSB is already present before the byte's first rising edge.
- R4: Every frame is exactly 32 rising edges, whatever the bytes contain. When unlocked, `cmdValid` is a one-cycle pulse after the 32nd edge.
- R5: The reply during the third byte equals the byte received second in the same frame, so it is 0x53 in an unlock frame. The replies during the first and second bytes are 0x00.
- R6: Until unlocked, `cmdValid`, `addrStrobe` and `cmdErase` stay low, and the fourth reply byte is 0x00.
- R7: When unlocked, the fourth reply byte equals `rdData`, sampled at the first falling `sck` edge after the 24th bit.
- R8: While `progResetN` is high (after synchronisation), the bit count, byte count, unlock flag and reply register are cleared. `miso` therefore reads 0, and the next frame starts at bit 0.
- R9: `cmdErase` pulses together with `cmdValid` when the first byte is 0xAC and bits [7:5] of the second byte are 3'b100.
- R10: When unlocked, `addrStrobe` pulses for one cycle after the 24th rising edge. At that point the first three bytes are valid. It never coincides with `cmdValid`.
- R11: A frame whose first two bytes are 0xAC, 0x53 sets `linkEnabled` when the frame ends. If the block was still locked, that frame raises no `cmdValid`.
- R12: Serial clock high and low phases of 3 system clocks are received and answered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| progResetN | input | 1 | Target reset pin; low selects programming |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial reply data to host |
| rdData | input | 8 | Read data from the execution unit |
| cmdOp | output | 8 | First byte of the frame |
| cmdAddrHi | output | 8 | Second byte of the frame |
| cmdAddrLo | output | 8 | Third byte of the frame |
| cmdData | output | 8 | Fourth byte of the frame |
| addrStrobe | output | 1 | Pulse after the third byte of an unlocked frame |
| cmdValid | output | 1 | Pulse after a complete unlocked frame |
| cmdErase | output | 1 | Pulse marking a chip-erase frame |
| linkEnabled | output | 1 | Unlock flag |

## Verification
Each pin change takes two synchroniser flops to cross into the system clock domain. The edge flop then compares old and new values. As a result, `miso`, `addrStrobe` and `cmdValid` change on the third system clock edge after the `sck` transition that causes them. The bench holds each serial clock phase for six system clocks, or for three in the minimum-width frame. It reads `miso` on the last falling system clock edge of each low phase, just before it raises `sck`. Strobes are caught by a monitor on every falling system clock edge, and their counts are compared once a frame has finished.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int BYTE_BITS   = 8;
  localparam int FRAME_BYTES = 4;
  localparam int BIT_CNT_W   = $clog2(BYTE_BITS);
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam int KEY_POS     = 1;
  localparam int READ_POS    = FRAME_BYTES - 2;

  localparam logic [BYTE_BITS-1:0] UNLOCK_OP  = 8'hAC;
  localparam logic [BYTE_BITS-1:0] UNLOCK_KEY = 8'h53;
  localparam logic [2:0]           ERASE_TAG  = 3'b100;

  typedef enum logic [1:0] {
    REPLY_ZERO = 2'd0,
    REPLY_ECHO = 2'd1,
    REPLY_READ = 2'd2
  } reply_e;

  typedef struct packed {
    logic             shiftIn;
    logic             capture;
    logic [IDX_W-1:0] captureIdx;
    logic             loadTx;
    logic             shiftTx;
    logic             clearTx;
    reply_e           replySel;
  } ctrl_t;
endpackage

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  sckPin,
  input  logic                                  mosiPin,
  input  logic                                  progResetNPin,
  input  ctrl_t                                 ctrl,
  input  logic [BYTE_BITS-1:0]                  rdData,
  output logic                                  sckRise,
  output logic                                  sckFall,
  output logic                                  progActive,
  output logic [FRAME_BYTES-1:0][BYTE_BITS-1:0] frameBytes,
  output logic                                  miso
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]          sckSync, mosiSync, rstSync;
  logic                   sckLast;
  logic [BYTE_BITS-2:0]   shiftReg;
  logic [BYTE_BITS-1:0]   txReg;
  logic                   mosiBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      rstSync  <= '1;
      sckLast  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[LAST-1:0], sckPin};
      mosiSync <= {mosiSync[LAST-1:0], mosiPin};
      rstSync  <= {rstSync[LAST-1:0], progResetNPin};
      sckLast  <= sckSync[LAST];
    end
  end

  assign mosiBit    = mosiSync[LAST];
  assign sckRise    = sckSync[LAST] & ~sckLast;
  assign sckFall    = ~sckSync[LAST] & sckLast;
  assign progActive = ~rstSync[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctrl.shiftIn) shiftReg <= {shiftReg[BYTE_BITS-3:0], mosiBit};
  end

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : gFrame
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) frameBytes[g] <= '0;
      else if (ctrl.capture && ctrl.captureIdx == IDX_W'(g))
        frameBytes[g] <= {shiftReg, mosiBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (ctrl.clearTx) begin
      txReg <= '0;
    end else if (ctrl.loadTx) begin
      case (ctrl.replySel)
        REPLY_ECHO: txReg <= frameBytes[KEY_POS];
        REPLY_READ: txReg <= rdData;
        default:    txReg <= '0;
      endcase
    end else if (ctrl.shiftTx) begin
      txReg <= {txReg[BYTE_BITS-2:0], 1'b0};
    end
  end

  assign miso = txReg[BYTE_BITS-1];
endmodule

// File: rtl/isp_control.sv
module isp_control
  import isp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sckRise,
  input  logic                 sckFall,
  input  logic                 progActive,
  input  logic [BYTE_BITS-1:0] opByte,
  input  logic [BYTE_BITS-1:0] keyByte,
  output ctrl_t                ctrl,
  output logic                 addrStrobe,
  output logic                 cmdValid,
  output logic                 cmdErase,
  output logic                 linkEnabled
);
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0]     byteIdx;
  logic                 loadPend;
  reply_e               replyNext;
  logic                 byteEnd, frameEnd, isUnlock, isErase;

  assign byteEnd  = sckRise && (bitCnt == BIT_CNT_W'(BYTE_BITS - 1));
  assign frameEnd = byteEnd && (byteIdx == IDX_W'(FRAME_BYTES - 1));
  assign isUnlock = (opByte == UNLOCK_OP) && (keyByte == UNLOCK_KEY);
  assign isErase  = (opByte == UNLOCK_OP) &&
                    (keyByte[BYTE_BITS-1 -: 3] == ERASE_TAG);

  always_comb begin
    ctrl            = '0;
    ctrl.shiftIn    = progActive && sckRise;
    ctrl.capture    = progActive && byteEnd;
    ctrl.captureIdx = byteIdx;
    ctrl.loadTx     = progActive && sckFall && loadPend;
    ctrl.shiftTx    = progActive && sckFall && !loadPend;
    ctrl.clearTx    = !progActive;
    ctrl.replySel   = replyNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= '0;
      byteIdx     <= '0;
      loadPend    <= 1'b0;
      replyNext   <= REPLY_ZERO;
      linkEnabled <= 1'b0;
      addrStrobe  <= 1'b0;
      cmdValid    <= 1'b0;
      cmdErase    <= 1'b0;
    end else if (!progActive) begin
      bitCnt      <= '0;
      byteIdx     <= '0;
      loadPend    <= 1'b0;
      replyNext   <= REPLY_ZERO;
      linkEnabled <= 1'b0;
      addrStrobe  <= 1'b0;
      cmdValid    <= 1'b0;
      cmdErase    <= 1'b0;
    end else begin
      addrStrobe <= 1'b0;
      cmdValid   <= 1'b0;
      cmdErase   <= 1'b0;
      if (sckRise) bitCnt <= bitCnt + 1'b1;
      if (ctrl.loadTx) loadPend <= 1'b0;
      if (byteEnd) begin
        byteIdx  <= byteIdx + 1'b1;
        loadPend <= 1'b1;
        if (byteIdx == IDX_W'(KEY_POS))
          replyNext <= REPLY_ECHO;
        else if (byteIdx == IDX_W'(READ_POS))
          replyNext <= linkEnabled ? REPLY_READ : REPLY_ZERO;
        else
          replyNext <= REPLY_ZERO;
        if (byteIdx == IDX_W'(READ_POS)) addrStrobe <= linkEnabled;
      end
      if (frameEnd) begin
        cmdValid <= linkEnabled;
        cmdErase <= linkEnabled && isErase;
        if (isUnlock) linkEnabled <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isp_frontend.sv
module isp_frontend
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       progResetN,
  input  logic       sck,
  input  logic       mosi,
  output logic       miso,
  input  logic [7:0] rdData,
  output logic [7:0] cmdOp,
  output logic [7:0] cmdAddrHi,
  output logic [7:0] cmdAddrLo,
  output logic [7:0] cmdData,
  output logic       addrStrobe,
  output logic       cmdValid,
  output logic       cmdErase,
  output logic       linkEnabled
);
  ctrl_t                                 ctrl;
  logic                                  sckRise, sckFall, progActive;
  logic [FRAME_BYTES-1:0][BYTE_BITS-1:0] frameBytes;

  isp_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .sckPin(sck), .mosiPin(mosi),
    .progResetNPin(progResetN), .ctrl(ctrl), .rdData(rdData),
    .sckRise(sckRise), .sckFall(sckFall), .progActive(progActive),
    .frameBytes(frameBytes), .miso(miso)
  );

  isp_control i_control (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .progActive(progActive), .opByte(frameBytes[0]),
    .keyByte(frameBytes[KEY_POS]), .ctrl(ctrl),
    .addrStrobe(addrStrobe), .cmdValid(cmdValid), .cmdErase(cmdErase),
    .linkEnabled(linkEnabled)
  );

  assign cmdOp     = frameBytes[0];
  assign cmdAddrHi = frameBytes[1];
  assign cmdAddrLo = frameBytes[2];
  assign cmdData   = frameBytes[3];
endmodule

// File: rtl/isp_frontend_checker.sv
module isp_frontend_checker (
  input logic clk,
  input logic rstN,
  input logic progActive,
  input logic sckFall,
  input logic miso,
  input logic addrStrobe,
  input logic cmdValid,
  input logic cmdErase,
  input logic linkEnabled
);
  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rstN) !$stable(miso) |-> ($past(sckFall) || !$past(progActive))); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) cmdValid |=> !cmdValid); // R4
  AST_VALID_GATED: assert property (@(posedge clk) disable iff (!rstN) (cmdValid || addrStrobe) |-> linkEnabled); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN) !progActive |=> (!linkEnabled && !cmdValid && !addrStrobe)); // R8
  AST_ERASE_QUAL: assert property (@(posedge clk) disable iff (!rstN) cmdErase |-> cmdValid); // R9
  AST_STROBE_APART: assert property (@(posedge clk) disable iff (!rstN) $onehot0({cmdValid, addrStrobe})); // R10
endmodule

bind isp_frontend isp_frontend_checker i_checker (
  .clk(clk), .rstN(rstN), .progActive(progActive), .sckFall(sckFall),
  .miso(miso), .addrStrobe(addrStrobe), .cmdValid(cmdValid),
  .cmdErase(cmdErase), .linkEnabled(linkEnabled)
);

// File: tb/test_isp_frontend.sv
`timescale 1ns/1ps
module test_isp_frontend;
  logic clk = 1'b0, rstN = 1'b0, progResetN = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, addrStrobe, cmdValid, cmdErase, linkEnabled;
  logic [7:0] rdData, cmdOp, cmdAddrHi, cmdAddrLo, cmdData;
  int checkCnt = 0, failCnt = 0;
  int validCnt = 0, addrCnt = 0, eraseCnt = 0;
  logic [31:0] capFrame;
  logic [23:0] capHead;
  logic capErase;
  bit done = 0, expEn = 0;

  always #2.5 clk = ~clk;

  isp_frontend i_isp_frontend (
    .clk(clk), .rstN(rstN), .progResetN(progResetN), .sck(sck), .mosi(mosi),
    .miso(miso), .rdData(rdData), .cmdOp(cmdOp), .cmdAddrHi(cmdAddrHi),
    .cmdAddrLo(cmdAddrLo), .cmdData(cmdData), .addrStrobe(addrStrobe),
    .cmdValid(cmdValid), .cmdErase(cmdErase), .linkEnabled(linkEnabled)
  );

  // Execution-unit model: read data derived from the header bytes
  assign rdData = cmdOp ^ cmdAddrLo ^ 8'h5A;

  always @(negedge clk) begin
    if (cmdValid) begin
      validCnt++;
      capFrame = {cmdOp, cmdAddrHi, cmdAddrLo, cmdData};
      capErase = cmdErase;
    end
    if (addrStrobe) begin
      addrCnt++;
      capHead = {cmdOp, cmdAddrHi, cmdAddrLo};
    end
    if (cmdErase) eraseCnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sendBits(input int n, input logic [31:0] bits, input int half,
                          output logic [31:0] reply);
    reply = '0;
    for (int b = n - 1; b >= 0; b--) begin
      sck = 1'b0; mosi = bits[b];
      repeat (half) @(negedge clk);
      reply[b] = miso;
      sck = 1'b1;
      repeat (half) @(negedge clk);
    end
    sck = 1'b0;
    repeat (half) @(negedge clk);
  endtask

  task automatic doFrame(input logic [7:0] b0, b1, b2, b3, input int half);
    logic [31:0] reply;
    int v0, a0, e0;
    bit unlock, erase;
    v0 = validCnt; a0 = addrCnt; e0 = eraseCnt;
    unlock = (b0 == 8'hAC) && (b1 == 8'h53);
    erase  = (b0 == 8'hAC) && (b1[7:5] == 3'b100);
    sendBits(32, {b0, b1, b2, b3}, half, reply);
    chk("R5 first two reply bytes zero", {16'h0, reply[31:16]}, 32'h0);
    chk("R5 third reply echoes second byte", {24'h0, reply[15:8]}, {24'h0, b1});
    chk(expEn ? "R7 fourth reply is read data" : "R6 fourth reply zero when locked",
        {24'h0, reply[7:0]}, expEn ? {24'h0, b0 ^ b2 ^ 8'h5A} : 32'h0);
    chk(expEn ? "R4 one cmdValid per frame" : "R6 R11 no cmdValid when locked",
        validCnt - v0, expEn ? 1 : 0);
    chk("R10 addrStrobe count", addrCnt - a0, expEn ? 1 : 0);
    chk("R9 cmdErase count", eraseCnt - e0, (expEn && erase) ? 1 : 0);
    if (expEn) begin
      chk("R2 frame bytes", capFrame, {b0, b1, b2, b3});
      chk("R10 header at addrStrobe", {8'h0, capHead}, {8'h0, b0, b1, b2});
      chk("R9 erase with valid", {31'h0, capErase}, {31'h0, erase});
    end
    expEn = expEn || unlock;
    chk("R11 linkEnabled after frame", {31'h0, linkEnabled}, {31'h0, expEn});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] junk;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 miso after reset", {31'h0, miso}, 32'h0);
    chk("R1 linkEnabled after reset", {31'h0, linkEnabled}, 32'h0);
    chk("R1 no strobes after reset", validCnt + addrCnt + eraseCnt, 0);

    progResetN = 1'b0;
    repeat (5) @(negedge clk);
    doFrame(8'h20, 8'h00, 8'h11, 8'h00, 6);   // locked read: R6
    doFrame(8'hAC, 8'h80, 8'h00, 8'h00, 6);   // locked erase: R6 R9
    sendBits(12, 32'hABC, 6, junk);           // host out of step
    progResetN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 miso cleared", {31'h0, miso}, 32'h0);
    progResetN = 1'b0;
    repeat (5) @(negedge clk);
    doFrame(8'hAC, 8'h53, 8'h12, 8'h34, 6);   // unlock: R5 R11 R8 realignment
    doFrame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 6);   // R4 content-independent count
    doFrame(8'hAC, 8'h9F, 8'h00, 8'h00, 6);   // R9 erase
    doFrame(8'h28, 8'h01, 8'hC3, 8'h00, 3);   // R12 minimum phases

    for (int i = 0; i < 40; i++) begin
      logic [7:0] b0;
      b0 = (i % 5 == 0) ? 8'hAC : 8'(i * 37 + 3);
      doFrame(b0, 8'(i * 53 + 7), 8'(i * 11), ~8'(i), 6);
    end

    sendBits(20, 32'h5A5A5, 6, junk);
    progResetN = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 unlock cleared", {31'h0, linkEnabled}, 32'h0);
    chk("R8 miso cleared after partial frame", {31'h0, miso}, 32'h0);
    progResetN = 1'b0;
    expEn = 0;
    repeat (5) @(negedge clk);
    doFrame(8'h20, 8'h00, 8'h44, 8'h00, 6);   // R6 R8 locked again
    doFrame(8'hAC, 8'h53, 8'h00, 8'h00, 3);   // R11 R12
    doFrame(8'h30, 8'h00, 8'h02, 8'h00, 3);   // R7 R12

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule